// File: doc/BRIEF.md
# Dual-Memory Multiply-Accumulate Engine

This block is the arithmetic heart of a Harvard-style signal processor. It reads one operand from X memory and one from Y memory in the same cycle, multiplies them as signed two's-complement values, and adds the product into a wide accumulator. A pointer generator for each memory steps its address forward by one on every read. In steady state one product therefore enters the sum on every clock, the equivalent of `acc += *x++ * *y++`.

A job begins with a one-cycle start pulse. The pulse captures the two base addresses and a tap count, and a control bit chooses whether the accumulator is cleared first or keeps its previous sum. Each memory returns its data one cycle after the read strobe. A sticky done flag rises once the last product has been added. A scaled view of the accumulator is always available on a second output. It applies a programmable arithmetic right shift, with optional round-half-up.

Top module: `dual_port_mac`

## Requirements
- R1: While rst_ni is low and after its release, busy_o, done_o, x_rd_o and y_rd_o are 0 and acc_o is 0.
- R2: A start accepted at a clock edge makes the first read, in the cycle that follows, use x_base_i on x_addr_o and y_base_i on y_addr_o.
- R3: Each read advances both addresses by one for the next read, wrapping modulo 2^ADDR_W (from 255 to 0 at the default ADDR_W = 8).
- R4: A job with tap count N asserts x_rd_o and y_rd_o together on exactly N consecutive cycles.
- R5: Every read pair adds the signed product x_data_i * y_data_i, with data returned one cycle after the strobe, into acc_o. acc_o holds its value in all other cycles.
- R6: done_o goes low at the accepted start edge and rises on the (N+1)-th clock edge after it. It stays high, with busy_o low, until the next accepted start.
- R7: acc_keep_i = 0 at start clears acc_o before the job. acc_keep_i = 1 keeps the previous sum and adds to it.
- R8: A tap count of 0 issues no reads, leaves acc_o cleared or kept per R7, and raises done_o on the first edge after start.
- R9: With round_en_i = 0, result_o equals acc_o shifted right arithmetically by shift_i bits.
- R10: With round_en_i = 1 and shift_i > 0, 2^(shift_i-1) is added to acc_o before the arithmetic shift. With shift_i = 0, result_o equals acc_o.
- R11: The accumulator is 2*DATA_W + GUARD_W bits wide (40 at the defaults). 255 products of magnitude 2^30 sum without wrapping.
- R12: A start pulse during a running job is ignored: addresses, read count and sum continue unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse for a job |
| acc_keep_i | input | 1 | At start: 1 keeps the sum, 0 clears it |
| taps_i | input | CNT_W | Number of products to accumulate |
| x_base_i | input | ADDR_W | First X address |
| y_base_i | input | ADDR_W | First Y address |
| shift_i | input | SHIFT_W | Right shift applied to result_o |
| round_en_i | input | 1 | Round half up before the shift |
| x_rd_o | output | 1 | X memory read strobe |
| x_addr_o | output | ADDR_W | X memory address |
| x_data_i | input | DATA_W | X read data, one cycle after the strobe |
| y_rd_o | output | 1 | Y memory read strobe |
| y_addr_o | output | ADDR_W | Y memory address |
| y_data_i | input | DATA_W | Y read data, one cycle after the strobe |
| busy_o | output | 1 | Reads in progress |
| done_o | output | 1 | Sticky completion flag |
| acc_o | output | ACC_W | Accumulator |
| result_o | output | ACC_W | Shifted and optionally rounded accumulator |

## Verification
The engine runs against several memory patterns. A ramp times a constant shows whether the address sequence and its wrap are right. Mixed-sign operands with zeros separate signed from unsigned multiplication. Full-scale negative-times-negative and negative-times-positive runs of 255 taps show whether the guard bits absorb the sum without wrapping. Zero-tap jobs, keep-versus-clear starts and a stray start in mid-job show whether the control path is decoupled from the datapath. On fixed sums, shift and round settings separate truncation from rounding, including on negative values.

// File: rtl/dual_port_mac_pkg.sv
package dual_port_mac_pkg;

  function automatic int acc_w(int data_w, int guard_w);
    return 2 * data_w + guard_w;
  endfunction

  // pipeline tag travelling with each read pair
  typedef struct packed {
    logic valid;
    logic last;
  } mac_tag_t;

endpackage

// File: rtl/mac_addr_gen.sv
module mac_addr_gen #(
  parameter int ADDR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic              step_i,
  output logic [ADDR_W-1:0] addr_o
);

  logic [ADDR_W-1:0] ptr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     ptr_q <= '0;
    else if (load_i) ptr_q <= base_i;
    else if (step_i) ptr_q <= ptr_q + 1'b1;
  end

  assign addr_o = ptr_q;

  assert_ptr_load_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> addr_o == $past(base_i));

  assert_ptr_step_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !load_i) |=> addr_o == $past(addr_o) + 1'b1);

endmodule

// File: rtl/mac_seq.sv
module mac_seq
  import dual_port_mac_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             keep_i,
  input  logic [CNT_W-1:0] taps_i,
  output logic             start_ok_o,
  output logic             issue_o,
  output logic             clr_o,
  output logic             valid_o,
  output logic             done_o
);

  logic [CNT_W-1:0] cnt_q;
  logic             busy_q;
  logic             done_q;
  mac_tag_t         tag_q;

  // accept only when reads and the add stage are both idle
  assign start_ok_o = start_i && !busy_q && !tag_q.valid;
  assign clr_o      = start_ok_o && !keep_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
    end else if (start_ok_o) begin
      cnt_q  <= taps_i;
      busy_q <= (taps_i != '0);
    end else if (busy_q) begin
      cnt_q <= cnt_q - 1'b1;
      if (cnt_q == CNT_W'(1)) busy_q <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tag_q  <= '0;
      done_q <= 1'b0;
    end else begin
      tag_q.valid <= busy_q;
      tag_q.last  <= (busy_q && cnt_q == CNT_W'(1)) || (start_ok_o && taps_i == '0);
      if (start_ok_o)      done_q <= 1'b0;
      else if (tag_q.last) done_q <= 1'b1;
    end
  end

  assign issue_o = busy_q;
  assign valid_o = tag_q.valid;
  assign done_o  = done_q;

  assert_done_idle_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> !busy_q);

  assert_start_ignored_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && start_i) |=> cnt_q == $past(cnt_q) - 1'b1);

endmodule

// File: rtl/mac_core.sv
module mac_core #(
  parameter int DATA_W = 16,
  parameter int ACC_W  = 40
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              valid_i,
  input  logic [DATA_W-1:0] x_i,
  input  logic [DATA_W-1:0] y_i,
  output logic [ACC_W-1:0]  acc_o
);

  localparam int PROD_W = 2 * DATA_W;

  logic signed [PROD_W-1:0] prod;
  logic signed [ACC_W-1:0]  prod_ext;
  logic signed [ACC_W-1:0]  acc_q;

  assign prod     = $signed(x_i) * $signed(y_i);
  assign prod_ext = ACC_W'(prod);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      acc_q <= '0;
    else if (clr_i)   acc_q <= '0;
    else if (valid_i) acc_q <= acc_q + prod_ext;
  end

  assign acc_o = acc_q;

  assert_acc_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!valid_i && !clr_i) |=> $stable(acc_q));

  assert_acc_clear_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> acc_q == '0);

endmodule

// File: rtl/mac_round_shift.sv
module mac_round_shift #(
  parameter int ACC_W   = 40,
  parameter int SHIFT_W = 5
) (
  input  logic [ACC_W-1:0]   acc_i,
  input  logic [SHIFT_W-1:0] shift_i,
  input  logic               round_i,
  output logic [ACC_W-1:0]   result_o
);

  logic signed [ACC_W:0] ext;
  logic signed [ACC_W:0] bias;
  logic signed [ACC_W:0] sum;
  logic signed [ACC_W:0] shifted;

  always_comb begin
    ext  = {acc_i[ACC_W-1], acc_i};
    bias = '0;
    if (round_i && shift_i != '0)
      bias = (ACC_W+1)'(1) << (shift_i - 1'b1);
    // one extra bit keeps the rounding add from wrapping
    sum     = ext + bias;
    shifted = sum >>> shift_i;
  end

  assign result_o = shifted[ACC_W-1:0];

endmodule

// File: rtl/dual_port_mac.sv
module dual_port_mac #(
  parameter int DATA_W  = 16,
  parameter int ADDR_W  = 8,
  parameter int GUARD_W = 8,
  parameter int CNT_W   = 8,
  parameter int SHIFT_W = 5,
  localparam int ACC_W  = dual_port_mac_pkg::acc_w(DATA_W, GUARD_W)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic               acc_keep_i,
  input  logic [CNT_W-1:0]   taps_i,
  input  logic [ADDR_W-1:0]  x_base_i,
  input  logic [ADDR_W-1:0]  y_base_i,
  input  logic [SHIFT_W-1:0] shift_i,
  input  logic               round_en_i,
  output logic               x_rd_o,
  output logic [ADDR_W-1:0]  x_addr_o,
  input  logic [DATA_W-1:0]  x_data_i,
  output logic               y_rd_o,
  output logic [ADDR_W-1:0]  y_addr_o,
  input  logic [DATA_W-1:0]  y_data_i,
  output logic               busy_o,
  output logic               done_o,
  output logic [ACC_W-1:0]   acc_o,
  output logic [ACC_W-1:0]   result_o
);

  localparam int NPORT = 2;

  logic              start_ok, issue, clr, valid;
  logic [ADDR_W-1:0] base [NPORT];
  logic [ADDR_W-1:0] addr [NPORT];

  assign base[0] = x_base_i;
  assign base[1] = y_base_i;

  mac_seq #(.CNT_W(CNT_W)) u_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start_i),
    .keep_i    (acc_keep_i),
    .taps_i    (taps_i),
    .start_ok_o(start_ok),
    .issue_o   (issue),
    .clr_o     (clr),
    .valid_o   (valid),
    .done_o    (done_o)
  );

  for (genvar p = 0; p < NPORT; p++) begin : g_agen
    mac_addr_gen #(.ADDR_W(ADDR_W)) u_agen (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .load_i(start_ok),
      .base_i(base[p]),
      .step_i(issue),
      .addr_o(addr[p])
    );
  end

  mac_core #(.DATA_W(DATA_W), .ACC_W(ACC_W)) u_core (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (clr),
    .valid_i(valid),
    .x_i    (x_data_i),
    .y_i    (y_data_i),
    .acc_o  (acc_o)
  );

  mac_round_shift #(.ACC_W(ACC_W), .SHIFT_W(SHIFT_W)) u_rs (
    .acc_i   (acc_o),
    .shift_i (shift_i),
    .round_i (round_en_i),
    .result_o(result_o)
  );

  assign x_rd_o   = issue;
  assign y_rd_o   = issue;
  assign x_addr_o = addr[0];
  assign y_addr_o = addr[1];
  assign busy_o   = issue;

  assert_noshift_pass_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (shift_i == '0) |-> result_o == acc_o);

  assert_reads_end_done_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |=> done_o);

endmodule

// File: tb/dual_port_mac_tb_top.sv
module dual_port_mac_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0, keep = 1'b0, rnd = 1'b0;
  logic [7:0]  taps = '0, xb = '0, yb = '0;
  logic [4:0]  sh = '0;
  logic        x_rd, y_rd, busy, done;
  logic [7:0]  x_addr, y_addr;
  logic [15:0] x_data = '0, y_data = '0;
  logic [39:0] acc, res;

  int     n_chk = 0, n_err = 0, cyc = 0, rd_cnt = 0, pat = 0;
  longint exp_acc = 0;
  logic [15:0] addr_q [$];

  always #5ns clk = ~clk;

  dual_port_mac dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .acc_keep_i(keep), .taps_i(taps),
    .x_base_i(xb), .y_base_i(yb), .shift_i(sh), .round_en_i(rnd),
    .x_rd_o(x_rd), .x_addr_o(x_addr), .x_data_i(x_data),
    .y_rd_o(y_rd), .y_addr_o(y_addr), .y_data_i(y_data),
    .busy_o(busy), .done_o(done), .acc_o(acc), .result_o(res)
  );

  function automatic longint fx(int p, int a);
    case (p)
      0: return longint'(a + 1);
      1: return (a % 2 == 1) ? -longint'(a * 97) : longint'(a * 61);
      default: return -32768;
    endcase
  endfunction

  function automatic longint fy(int p, int a);
    case (p)
      0: return 3;
      1: return longint'(a % 3 - 1);
      2: return -32768;
      default: return 32767;
    endcase
  endfunction

  // memory model: data one cycle after the strobe
  always @(posedge clk) begin
    if (x_rd) x_data <= 16'(fx(pat, int'(x_addr)));
    if (y_rd) y_data <= 16'(fy(pat, int'(y_addr)));
  end

  task automatic check(bit ok, string req, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  // monitor: pop expected address pairs as reads appear
  always @(negedge clk) begin
    if (rst_n && (x_rd || y_rd)) begin
      rd_cnt++;
      check(x_rd == y_rd, "R4 strobe pair", longint'(y_rd), longint'(x_rd));
      if (addr_q.size() == 0) begin
        check(1'b0, "R4 extra read", longint'(rd_cnt), 0);
      end else begin
        logic [15:0] e;
        e = addr_q.pop_front();
        check({x_addr, y_addr} == e, "R2 R3 addr", longint'({x_addr, y_addr}), longint'(e));
      end
    end
  end

  task automatic run_job(int p, int xbase, int ybase, int n, bit kp, int poke, string req);
    int lat = 0;
    pat = p;
    if (!kp) exp_acc = 0;
    for (int i = 0; i < n; i++) begin
      int xa = (xbase + i) % 256;
      int ya = (ybase + i) % 256;
      exp_acc += fx(p, xa) * fy(p, ya);
      addr_q.push_back({8'(xa), 8'(ya)});
    end
    rd_cnt = 0;
    @(negedge clk);
    start = 1'b1; keep = kp; taps = 8'(n); xb = 8'(xbase); yb = 8'(ybase);
    @(negedge clk);
    start = 1'b0; xb = 8'h55; yb = 8'hAA; taps = 8'd3;
    check(done == 1'b0, "R6 done cleared", longint'(done), 0);
    while (lat < 2000) begin
      start = (poke > 0 && lat == poke);  // stray start for R12
      @(negedge clk);
      lat++;
      if (done) break;
    end
    start = 1'b0;
    check(lat == n + 1, {req, " R6 latency"}, longint'(lat), longint'(n + 1));
    check(rd_cnt == n, {req, " R4 read count"}, longint'(rd_cnt), longint'(n));
    check($signed(acc) == exp_acc, {req, " R5 sum"}, longint'($signed(acc)), exp_acc);
    repeat (2) @(negedge clk);
    check(done && !busy, "R6 done sticky", longint'({done, busy}), 2);
    check($signed(acc) == exp_acc, "R5 acc hold", longint'($signed(acc)), exp_acc);
  endtask

  task automatic check_res(int s, bit r, string req);
    longint e = exp_acc;
    if (r && s > 0) e += longint'(1) << (s - 1);
    e = e >>> s;
    sh = 5'(s); rnd = r;
    #1ns;
    check($signed(res) == e, req, longint'($signed(res)), e);
  endtask

  initial begin : watchdog
    while (cyc < 200000) begin
      @(posedge clk);
      cyc++;
    end
    check(1'b0, "watchdog", longint'(cyc), 0);
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    check({busy, done, x_rd, y_rd} == 4'b0 && acc == '0, "R1 in reset",
          longint'({busy, done, x_rd, y_rd}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check({busy, done, x_rd, y_rd} == 4'b0 && acc == '0, "R1 after reset",
          longint'(acc), 0);

    run_job(0, 0, 10, 8, 1'b0, 0, "R2 ramp");
    check_res(0, 1'b1, "R10 zero shift rounded");
    check_res(0, 1'b0, "R9 zero shift");
    check_res(3, 1'b0, "R9 shift 3");
    check_res(3, 1'b1, "R10 shift 3 round");

    run_job(1, 250, 5, 12, 1'b0, 0, "R3 wrap signed");
    check_res(5, 1'b0, "R9 shift 5 signed");
    check_res(5, 1'b1, "R10 shift 5 signed round");
    check_res(1, 1'b1, "R10 shift 1 round");

    run_job(1, 3, 3, 5, 1'b1, 0, "R7 keep");
    run_job(0, 7, 7, 0, 1'b1, 0, "R8 zero taps keep");
    run_job(0, 7, 7, 0, 1'b0, 0, "R8 zero taps clear R7");
    check(acc == '0, "R8 R7 cleared", longint'(acc), 0);

    run_job(2, 0, 0, 255, 1'b0, 0, "R11 full scale");
    check_res(20, 1'b1, "R10 shift 20 round");
    run_job(3, 0, 0, 255, 1'b1, 0, "R11 mixed sign");

    run_job(0, 20, 100, 10, 1'b0, 4, "R12 stray start");
    check(addr_q.size() == 0, "R12 queue empty", longint'(addr_q.size()), 0);

    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

endmodule